// File: doc/BRIEF.md
# Receive flow-control unit with hysteretic request-to-send

This block sits on the receive side of one serial channel. Bytes from the deserializer go into a 64-entry FIFO. The block drives an active-low request-to-send output so that the far end pauses before the FIFO can overflow.

Two thresholds are packed into one 8-bit register:
- the low nibble sets the level at which sending is halted;
- the high nibble sets the level at which sending resumes.

Each nibble counts in steps of four entries. Between the two levels the output holds its last state. Because the highest halt level is 60, four entries are always still free when the request drops. A peer that has already begun one more character can therefore finish it without loss.

On the transmit side, a clear-to-send gate gives permission to start a character. While the gate is enabled and the peer's active-low clear-to-send is high, no new character may start. A character that is already being shifted out is not affected, because the gate only acts on start requests. If the request output of one unit is looped to the clear-to-send input of another, the sender stalls before that receiver's FIFO is full.

Top module: `rxflow_ctrl`

## Requirements
- R1: The threshold register is written from `thr_wdata` on a cycle with `thr_wr` high, and resets to 8'h8F. Bits [3:0] give the halt level (nibble × 4). Bits [7:4] give the resume level (nibble × 4).
- R2: With `auto_rts_en` high, `rts_n` is high on the cycle after the FIFO fill level is at or above the halt level. The only exception is a pending resume under R3.
- R3: Once `rts_n` is high under auto control, it stays high until the fill level is at or below the resume level. It then goes low one cycle later. While the level lies strictly between resume and halt, `rts_n` keeps its previous value.
- R4: The FIFO stores up to 64 bytes and returns them in arrival order. The byte appears on `rd_data` one cycle after a `rd_en` with the FIFO not empty. `level` counts the stored bytes, `empty` means level 0 and `full` means level 64.
- R5: A byte arriving after `rts_n` has gone high is stored without raising `overrun`, as long as the FIFO is not full.
- R6: A byte that arrives while the FIFO is full and nothing is popped is dropped. The level stays at 64 and the sticky `overrun` flag is set. A cycle with `ovr_clr` high clears the flag, unless a drop happens in the same cycle.
- R7: With `auto_rts_en` high, `rts_n` is high on the cycle after the FIFO is full.
- R8: With `auto_rts_en` low, `rts_n` equals the inverse of `sw_rts`, one cycle later.
- R9: `tx_start` is high one cycle after a cycle in which `tx_req` is high and either `auto_cts_en` is low or `cts_n` is low. Otherwise `tx_start` is low.
- R10: During reset, `level` is 0, `empty` is 1, `full` is 0, `overrun` is 0, `rts_n` is 1 and `tx_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Popped byte, valid one cycle after `rd_en` |
| level | output | 7 | Number of bytes stored |
| empty | output | 1 | FIFO holds no byte |
| full | output | 1 | FIFO holds 64 bytes |
| overrun | output | 1 | Sticky: a byte was dropped |
| ovr_clr | input | 1 | Clears `overrun` |
| thr_wr | input | 1 | Write strobe for the threshold register |
| thr_wdata | input | 8 | [3:0] halt nibble, [7:4] resume nibble |
| auto_rts_en | input | 1 | Request output follows the FIFO level |
| sw_rts | input | 1 | Software request, used when auto control is off (1 = request) |
| rts_n | output | 1 | Request to send, active low |
| auto_cts_en | input | 1 | Enables the clear-to-send gate |
| cts_n | input | 1 | Peer clear-to-send, active low |
| tx_req | input | 1 | Transmitter wants to start a character |
| tx_start | output | 1 | Permission to start, registered |

## Verification
The FIFO flags and `level` change on the same edge that takes a push or a pop. `rd_data` carries the popped byte from that same edge. `rts_n` lags the level by one further edge, because it is decided from the registered level.

`tx_start` and the software path of `rts_n` follow their inputs after a single edge. The bench drives inputs on falling edges and pulses each push or pop for one cycle. It then waits one more full cycle before sampling `rts_n`, so every result is read only after the edge that produces it.

The bench runs sweeps that fill the FIFO to full and drain it completely, over five threshold pairs. After every step it compares the outputs with a level and hysteresis model kept in the bench.

// File: rtl/rxflow_pkg.sv
package rxflow_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic [NIB_W-1:0] resume;
    logic [NIB_W-1:0] halt;
  } thr_reg_t;

  function automatic int unsigned nib_to_level(logic [NIB_W-1:0] nib, int unsigned step);
    return int'(nib) * step;
  endfunction
endpackage

// File: rtl/rxflow_fifo.sv
module rxflow_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              is_empty,
  output logic              is_full,
  output logic              ovr,
  input  logic              ovr_clr
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              do_pop, accept, drop;

  assign do_pop = pop_req && !is_empty;
  assign accept = push && (!is_full || do_pop);
  assign drop   = push && !accept;

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wdata;
    if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
      is_empty <= 1'b1;
      is_full <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (accept) wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      case ({accept, do_pop})
        2'b10: begin
          count <= count + 1'b1;
          is_empty <= 1'b0;
          is_full <= (count == CNT_W'(DEPTH - 1));
        end
        2'b01: begin
          count <= count - 1'b1;
          is_full <= 1'b0;
          is_empty <= (count == CNT_W'(1));
        end
        default: ;
      endcase
      if (drop) ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_full_flag_R4: assert property (@(posedge clk) disable iff (rst)
    is_full == (count == CNT_W'(DEPTH)));
  assert_drop_sets_ovr_R6: assert property (@(posedge clk) disable iff (rst)
    (push && is_full && !pop_req) |=> (ovr && $stable(count)));
endmodule

// File: rtl/rxflow_rts.sv
module rxflow_rts #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned STEP  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       count,
  input  rxflow_pkg::thr_reg_t   thr,
  input  logic                   auto_en,
  input  logic                   sw_req,
  output logic                   rts_n
);
  logic [CNT_W-1:0] halt_lvl, resume_lvl;
  logic             halted, halted_nx;

  assign halt_lvl   = CNT_W'(rxflow_pkg::nib_to_level(thr.halt, STEP));
  assign resume_lvl = CNT_W'(rxflow_pkg::nib_to_level(thr.resume, STEP));

  always_comb begin
    halted_nx = halted;
    if (!halted && count >= halt_lvl) halted_nx = 1'b1;
    else if (halted && count <= resume_lvl) halted_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      rts_n  <= 1'b1;
    end else begin
      halted <= halted_nx;
      rts_n  <= auto_en ? halted_nx : !sw_req;
    end
  end

  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> ($past(count) >= $past(halt_lvl)));
  assert_resume_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> ($past(count) <= $past(resume_lvl)));
  assert_sw_path_R8: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (rts_n == !$past(sw_req)));
endmodule

// File: rtl/rxflow_cts_gate.sv
module rxflow_cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic cts_n,
  input  logic tx_req,
  output logic tx_start
);
  always_ff @(posedge clk) begin
    if (rst) tx_start <= 1'b0;
    else     tx_start <= tx_req && (!auto_en || !cts_n);
  end

  assert_cts_block_R9: assert property (@(posedge clk) disable iff (rst)
    (auto_en && cts_n) |=> !tx_start);
  assert_cts_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !cts_n) |=> tx_start);
endmodule

// File: rtl/rxflow_ctrl.sv
module rxflow_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned STEP   = 4,
  parameter logic [7:0]  THR_RESET = 8'h8F,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              overrun,
  input  logic              ovr_clr,
  input  logic              thr_wr,
  input  logic [7:0]        thr_wdata,
  input  logic              auto_rts_en,
  input  logic              sw_rts,
  output logic              rts_n,
  input  logic              auto_cts_en,
  input  logic              cts_n,
  input  logic              tx_req,
  output logic              tx_start
);
  rxflow_pkg::thr_reg_t thr_q;

  always_ff @(posedge clk) begin
    if (rst)         thr_q <= rxflow_pkg::thr_reg_t'(THR_RESET);
    else if (thr_wr) thr_q <= rxflow_pkg::thr_reg_t'(thr_wdata);
  end

  rxflow_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(rx_valid), .wdata(rx_data),
    .pop_req(rd_en), .rdata(rd_data), .count(level),
    .is_empty(empty), .is_full(full), .ovr(overrun), .ovr_clr(ovr_clr)
  );

  rxflow_rts #(.CNT_W(CNT_W), .STEP(STEP)) u_rts (
    .clk(clk), .rst(rst), .count(level), .thr(thr_q),
    .auto_en(auto_rts_en), .sw_req(sw_rts), .rts_n(rts_n)
  );

  rxflow_cts_gate u_cts (
    .clk(clk), .rst(rst), .auto_en(auto_cts_en), .cts_n(cts_n),
    .tx_req(tx_req), .tx_start(tx_start)
  );

  assert_full_stops_peer_R7: assert property (@(posedge clk) disable iff (rst)
    (full && auto_rts_en) |=> rts_n);
  assert_thr_write_R1: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (thr_q == $past(thr_wdata)));
endmodule

// File: tb/rxflow_ctrl_tb.sv
module rxflow_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rd_en = 0, ovr_clr = 0, thr_wr = 0;
  logic [7:0] rx_data = 0, thr_wdata = 0;
  logic auto_rts_en = 1, sw_rts = 0, auto_cts_en = 0, cts_n = 1, tx_req = 0;
  logic [7:0] rd_data;
  logic [6:0] level;
  logic empty, full, overrun, rts_n, tx_start;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int lvl_m = 0, halt_m = 60, res_m = 32;
  bit hold_m = 0;

  always #5ns clk = ~clk;

  rxflow_ctrl u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rd_en(rd_en),
    .rd_data(rd_data), .level(level), .empty(empty), .full(full), .overrun(overrun),
    .ovr_clr(ovr_clr), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .rts_n(rts_n),
    .auto_cts_en(auto_cts_en), .cts_n(cts_n), .tx_req(tx_req), .tx_start(tx_start)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_eval();
    if (!hold_m && lvl_m >= halt_m) hold_m = 1;
    else if (hold_m && lvl_m <= res_m) hold_m = 0;
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
    if (lvl_m < 64) lvl_m++;
    model_eval();
    @(negedge clk);
    check(int'(level) == lvl_m, "R4", level, lvl_m);
    check(rts_n == hold_m, tag, rts_n, hold_m);
  endtask

  task automatic pop(input logic [7:0] exp_b);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    lvl_m--;
    check(rd_data == exp_b, "R4", rd_data, exp_b);
    model_eval();
    @(negedge clk);
    check(rts_n == hold_m, "R3", rts_n, hold_m);
  endtask

  initial begin
    logic [7:0] pairs [5];
    pairs[0] = 8'h8F; pairs[1] = 8'h14; pairs[2] = 8'h08;
    pairs[3] = 8'h12; pairs[4] = 8'hEF;
    repeat (3) @(negedge clk);
    check(level == 0, "R10", level, 0);
    check(empty == 1, "R10", empty, 1);
    check(full == 0, "R10", full, 0);
    check(overrun == 0, "R10", overrun, 0);
    check(rts_n == 1, "R10", rts_n, 1);
    check(tx_start == 0, "R10", tx_start, 0);
    rst = 0;
    @(negedge clk); @(negedge clk);
    check(rts_n == 0, "R2", rts_n, 0);

    for (int s = 0; s < 5; s++) begin
      if (s > 0) begin
        thr_wr = 1; thr_wdata = pairs[s];
        @(negedge clk);
        thr_wr = 0;
        halt_m = int'(pairs[s][3:0]) * 4;
        res_m  = int'(pairs[s][7:4]) * 4;
        model_eval();
        @(negedge clk);
        check(rts_n == hold_m, "R1", rts_n, hold_m);
      end
      for (int i = 0; i < 64; i++) begin
        push(8'((s * 37 + i) & 8'hFF), (lvl_m >= halt_m) ? "R5" : "R2");
        check(overrun == 0, "R5", overrun, 0);
      end
      check(full == 1, "R4", full, 1);
      check(rts_n == 1, "R7", rts_n, 1);
      push(8'hA5, "R7");
      check(overrun == 1, "R6", overrun, 1);
      check(level == 64, "R6", level, 64);
      ovr_clr = 1;
      @(negedge clk);
      ovr_clr = 0;
      check(overrun == 0, "R6", overrun, 0);
      for (int i = 0; i < 64; i++) pop(8'((s * 37 + i) & 8'hFF));
      check(empty == 1, "R4", empty, 1);
    end

    auto_rts_en = 0; sw_rts = 1;
    @(negedge clk);
    check(rts_n == 0, "R8", rts_n, 0);
    sw_rts = 0;
    @(negedge clk);
    check(rts_n == 1, "R8", rts_n, 1);
    auto_rts_en = 1;

    tx_req = 1; auto_cts_en = 1; cts_n = 1;
    @(negedge clk);
    check(tx_start == 0, "R9", tx_start, 0);
    cts_n = 0;
    @(negedge clk);
    check(tx_start == 1, "R9", tx_start, 1);
    cts_n = 1; auto_cts_en = 0;
    @(negedge clk);
    check(tx_start == 1, "R9", tx_start, 1);
    tx_req = 0;
    @(negedge clk);
    check(tx_start == 0, "R9", tx_start, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule